// File: doc/BRIEF.md
# Paired-Channel Sample Phase Aligner

This block sits between six synchronously clocked modulators and their decimation filters. It delays one stream of a channel pair by a whole number of modulator samples, so that a fixed phase error of a current or voltage sensor can be cancelled before the filtering. The channels are grouped into three fixed pairs: (0,1), (2,3) and (4,5). Each pair has one signed 12-bit phase setting, and the sign of that setting chooses which member of the pair is held back.

The block runs on a system clock. A one-cycle strobe marks each modulator sample. The phase words and the oversampling selection are taken in only on a conversion-restart pulse, which is given when the filters are resynchronised. After a restart, the delayed stream outputs zero samples until its delay line has been refilled with samples taken since that restart. The other stream of the pair passes through unchanged. Every output goes through one register stage, so all six streams keep the same fixed latency.

Top module: `phase_pair_aligner`

## Requirements
- R1: During and straight after reset, all six outputs are zero and every pair has zero delay, so all streams pass straight through.
- R2: Pair (0,1) takes its setting from `phase_hi[11:0]`. Pair (2,3) takes its setting from `phase_hi[23:12]`. Pair (4,5) takes its setting from `phase_lo[11:0]`.
- R3: A setting is read as 12-bit two's complement. A positive value N delays the odd channel of the pair by N modulator samples. The even channel of that pair passes its current sample through.
- R4: A negative value -N delays the even channel of the pair by N samples. The odd channel of that pair passes its current sample through.
- R5: The applied delay is the magnitude of the setting, capped at OSR/2 and at the line depth 2^DLY_AW (1024 by default). OSR/2 is 16 shifted left by `osr_sel`, so `osr_sel` 0..7 gives OSR/2 from 16 up to 2048. A value of -2048 has magnitude 2048.
- R6: Changes to the phase words or to `osr_sel` have no effect until the next `restart` pulse.
- R7: After a restart that sets delay d > 0, the delayed channel outputs zero for the first d samples. It then outputs the sample taken d samples earlier. A sample strobed in the same cycle as `restart` is the first sample of the new conversion and is handled under the new setting.
- R8: The outputs change only in the clock cycle after a cycle with `mod_en` high. Between strobes they hold their value.
- R9: A setting of zero passes both channels of the pair through with only the one-register latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_en | input | 1 | Strobe marking one modulator sample |
| restart | input | 1 | Start of a fresh conversion; latches the settings |
| osr_sel | input | 3 | Oversampling selection, OSR = 32 << osr_sel |
| phase_hi | input | 24 | Settings for pairs (0,1) in [11:0] and (2,3) in [23:12] |
| phase_lo | input | 12 | Setting for pair (4,5) |
| mod_in | input | 6*MOD_W | Six sample streams, channel k at [k*MOD_W +: MOD_W] |
| mod_out | output | 6*MOD_W | Six aligned streams, same packing |

## Verification
Two functions can fall in the same cycle: a conversion restart and a sample strobe. When they coincide, the sample in that cycle must be counted under the new delay as the first sample of the refill, and it must not be counted under the old delay. The bench drives `restart` both with and without a simultaneous `mod_en`. It also uses random strobe densities. A queue-based model keeps the full history of each channel and a count of samples since the last restart. Every output is compared with this model on every clock, so an off-by-one in the refill gating or in the choice of setting shows up as a sample mismatch.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int NUM_PAIRS = 3;
  localparam int NUM_CH    = 2 * NUM_PAIRS;
  localparam int FIELD_W   = 12;

  // half of the oversampling ratio: 16 << sel (16..2048)
  function automatic logic [12:0] half_osr(input logic [2:0] sel);
    return 13'd16 << sel;
  endfunction

  // magnitude of a two's complement 12-bit setting (0..2048)
  function automatic logic [12:0] field_mag(input logic [FIELD_W-1:0] f);
    if (f[FIELD_W-1]) return 13'h1000 - {1'b0, f};
    return {1'b0, f};
  endfunction

  function automatic logic [12:0] min13(input logic [12:0] a, input logic [12:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/pdc_phase_decode.sv
module pdc_phase_decode #(
  parameter int DLY_AW = 10
) (
  input  logic [pdc_pkg::FIELD_W-1:0] field,
  input  logic [2:0]                  osr_sel,
  output logic [DLY_AW:0]             delay,
  output logic                        odd_sel
);
  localparam int DEPTH = 1 << DLY_AW;

  logic [12:0] mag, limit, clamped;

  always_comb begin
    mag     = pdc_pkg::field_mag(field);
    limit   = pdc_pkg::min13(pdc_pkg::half_osr(osr_sel), 13'(DEPTH));
    clamped = pdc_pkg::min13(mag, limit);
    delay   = clamped[DLY_AW:0];
    odd_sel = ~field[pdc_pkg::FIELD_W-1];
  end
endmodule

// File: rtl/pdc_pair_line.sv
module pdc_pair_line #(
  parameter int MOD_W  = 4,
  parameter int DLY_AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic             restart,
  input  logic [DLY_AW:0]  new_delay,
  input  logic             new_odd,
  input  logic [MOD_W-1:0] in_even,
  input  logic [MOD_W-1:0] in_odd,
  output logic [MOD_W-1:0] out_even,
  output logic [MOD_W-1:0] out_odd
);
  localparam int DEPTH = 1 << DLY_AW;
  localparam int DW    = DLY_AW + 1;

  logic [MOD_W-1:0]  line_q [DEPTH];
  logic [DLY_AW-1:0] wp_q, rd_addr;
  logic [DW-1:0]     act_d_q, fill_q, eff_d, eff_fill, fill_nxt;
  logic              act_odd_q, eff_odd;
  logic              take_sample, new_conv, filled, even_held, odd_held;
  logic [MOD_W-1:0]  wr_data, delayed;

  assign take_sample = mod_en;
  assign new_conv    = restart;

  always_comb begin
    eff_d     = new_conv ? new_delay : act_d_q;
    eff_odd   = new_conv ? new_odd   : act_odd_q;
    eff_fill  = new_conv ? '0        : fill_q;
    rd_addr   = wp_q - eff_d[DLY_AW-1:0];
    filled    = (eff_fill >= eff_d);
    delayed   = filled ? line_q[rd_addr] : '0;
    wr_data   = eff_odd ? in_odd : in_even;
    fill_nxt  = (eff_fill == DW'(DEPTH)) ? eff_fill : eff_fill + 1'b1;
    even_held = (eff_d != '0) && !eff_odd;
    odd_held  = (eff_d != '0) &&  eff_odd;
  end

  always_ff @(posedge clk) begin
    if (take_sample) line_q[wp_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_d_q   <= '0;
      act_odd_q <= 1'b0;
      fill_q    <= '0;
      wp_q      <= '0;
      out_even  <= '0;
      out_odd   <= '0;
    end else begin
      if (new_conv) begin
        act_d_q   <= new_delay;
        act_odd_q <= new_odd;
      end
      if (take_sample) begin
        wp_q     <= wp_q + 1'b1;
        fill_q   <= fill_nxt;
        out_even <= even_held ? delayed : in_even;
        out_odd  <= odd_held  ? delayed : in_odd;
      end else if (new_conv) begin
        fill_q <= '0;
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take_sample |=> ($stable(out_even) && $stable(out_odd)));

  assert_setting_only_on_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !new_conv |=> ($stable(act_d_q) && $stable(act_odd_q)));

  assert_refill_odd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (new_conv && take_sample && new_delay != '0 && new_odd) |=> (out_odd == '0));

  assert_refill_even_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (new_conv && take_sample && new_delay != '0 && !new_odd) |=> (out_even == '0));

  assert_zero_passes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_sample && eff_d == '0) |=> (out_even == $past(in_even) && out_odd == $past(in_odd)));

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= DW'(DEPTH));

  assert_free_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_sample && odd_held) |=> (out_even == $past(in_even)));

  assert_free_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_sample && even_held) |=> (out_odd == $past(in_odd)));
endmodule

// File: rtl/phase_pair_aligner.sv
module phase_pair_aligner #(
  parameter int MOD_W  = 4,
  parameter int DLY_AW = 10   // line depth 2^DLY_AW, at most 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mod_en,
  input  logic                         restart,
  input  logic [2:0]                   osr_sel,
  input  logic [23:0]                  phase_hi,
  input  logic [11:0]                  phase_lo,
  input  logic [6*MOD_W-1:0]           mod_in,
  output logic [6*MOD_W-1:0]           mod_out
);
  localparam int NP = pdc_pkg::NUM_PAIRS;
  localparam int FW = pdc_pkg::FIELD_W;

  logic [FW-1:0] pair_field [NP];

  // R2: fixed mapping of settings onto pairs
  assign pair_field[0] = phase_hi[11:0];
  assign pair_field[1] = phase_hi[23:12];
  assign pair_field[2] = phase_lo;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic [DLY_AW:0] dly;
    logic            odd;

    pdc_phase_decode #(.DLY_AW(DLY_AW)) u_dec (
      .field   (pair_field[p]),
      .osr_sel (osr_sel),
      .delay   (dly),
      .odd_sel (odd)
    );

    pdc_pair_line #(.MOD_W(MOD_W), .DLY_AW(DLY_AW)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .mod_en    (mod_en),
      .restart   (restart),
      .new_delay (dly),
      .new_odd   (odd),
      .in_even   (mod_in [(2*p)*MOD_W   +: MOD_W]),
      .in_odd    (mod_in [(2*p+1)*MOD_W +: MOD_W]),
      .out_even  (mod_out[(2*p)*MOD_W   +: MOD_W]),
      .out_odd   (mod_out[(2*p+1)*MOD_W +: MOD_W])
    );
  end

  assert_reset_out_R1: assert property (@(posedge clk)
    !rst_n |=> (mod_out == '0));
endmodule

// File: tb/sim_phase_pair_aligner.sv
module sim_phase_pair_aligner;
  localparam int MW = 4;
  localparam int LINE = 1024;

  logic clk = 1'b0, rst_n = 1'b0, mod_en = 1'b0, restart = 1'b0;
  logic [2:0]  osr_sel = '0;
  logic [23:0] phase_hi = '0;
  logic [11:0] phase_lo = '0;
  logic [6*MW-1:0] mod_in = '0, mod_out;

  int checks = 0, errors = 0;
  int hist [6][$];
  int exp_v [6];
  int dly [3];
  bit odd_d [3];
  int since [3];

  always #5 clk = ~clk;

  phase_pair_aligner #(.MOD_W(MW), .DLY_AW(10)) u0 (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .restart(restart),
    .osr_sel(osr_sel), .phase_hi(phase_hi), .phase_lo(phase_lo),
    .mod_in(mod_in), .mod_out(mod_out));

  function automatic int model_delay(input logic [11:0] f, input int sel);
    int v, lim;
    v = (f >= 12'h800) ? int'(f) - 4096 : int'(f);
    if (v < 0) v = -v;
    lim = 16 * (1 << sel);
    if (lim > LINE) lim = LINE;
    return (v < lim) ? v : lim;
  endfunction

  task automatic compare(input string tag);
    for (int c = 0; c < 6; c++) begin
      int got = int'(mod_out[c*MW +: MW]);
      checks++;
      if (got !== exp_v[c]) begin
        errors++;
        $display("FAIL %s ch%0d got %0h exp %0h", tag, c, got, exp_v[c]);
      end
    end
  endtask

  task automatic step(input bit rs, input bit en, input string tag);
    compare(tag);
    restart = rs;
    mod_en  = en;
    mod_in  = 24'($urandom);
    if (rs) begin
      logic [11:0] fl [3];
      fl[0] = phase_hi[11:0]; fl[1] = phase_hi[23:12]; fl[2] = phase_lo;
      for (int p = 0; p < 3; p++) begin
        dly[p]   = model_delay(fl[p], int'(osr_sel));
        odd_d[p] = !fl[p][11];
        since[p] = 0;
      end
    end
    if (en) begin
      for (int c = 0; c < 6; c++) begin
        int p = c / 2;
        bit held = (dly[p] != 0) && (odd_d[p] == bit'(c % 2));
        hist[c].push_front(int'(mod_in[c*MW +: MW]));
        if (hist[c].size() > LINE + 8) void'(hist[c].pop_back());
        if (!held) exp_v[c] = hist[c][0];
        else if (since[p] >= dly[p]) exp_v[c] = hist[c][dly[p]];
        else exp_v[c] = 0;
      end
      for (int p = 0; p < 3; p++) since[p]++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n, input int pct, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, ($urandom % 100) < pct, tag);
  endtask

  initial begin
    for (int c = 0; c < 6; c++) exp_v[c] = 0;
    for (int p = 0; p < 3; p++) begin dly[p] = 0; odd_d[p] = 0; since[p] = 0; end
    mod_in = 24'hABCDEF;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");
    run(40, 50, "R9 zero setting");
    // pair0 +5 (odd), pair1 -3 (even), pair2 +7 (odd); restart with strobe
    phase_hi = {12'hFFD, 12'd5}; phase_lo = 12'd7; osr_sel = 3'd0;
    step(1'b1, 1'b1, "R2 R3 R4 R7 restart+strobe");
    run(120, 60, "R2 R3 R4 R7");
    // new words without restart must not matter
    phase_hi = {12'd9, 12'hFF0}; phase_lo = 12'hF00; osr_sel = 3'd5;
    run(80, 70, "R6 ignored");
    // clamp to OSR/2 = 16; restart without strobe
    phase_hi = {12'd100, 12'h800}; phase_lo = 12'd20; osr_sel = 3'd0;
    step(1'b1, 1'b0, "R5 R7 restart only");
    run(150, 60, "R5 R7 clamp16");
    osr_sel = 3'd3;
    step(1'b1, 1'b1, "R5 restart osr128");
    run(500, 80, "R5 clamp128");
    phase_hi = {12'h801, 12'h800}; phase_lo = 12'h7FF; osr_sel = 3'd7;
    step(1'b1, 1'b1, "R5 restart line cap");
    run(2300, 100, "R5 R7 line cap");
    run(200, 10, "R8 sparse strobes");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule